// File: doc/BRIEF.md
# Speculative Load Address Table

This block keeps a record of loads that a compiler has moved above earlier stores without being able to prove the addresses differ. When such a hoisted load executes, the pipeline writes its destination register tag, its byte address and its access size into the table. Every store that retires afterwards is compared with all live records. A record whose bytes the store overlaps is dropped.

At the load's original program position the pipeline issues a check carrying the same register tag. One cycle later the block answers. It either confirms that the early value is still good or raises a single redo request, which tells the pipeline to reissue the load. Reissuing the load and performing the memory access belong to other blocks.

Records are found by register tag. When every slot is in use, a round-robin pointer picks the slot to overwrite. A record that is displaced this way simply fails its later check, which is the safe outcome.

Top module: `spec_load_table`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `chk_resp_valid`, `chk_ok` and `chk_redo` are low. After reset no record is live, so the first check on any tag answers with a redo.
- R2: A check issued in any cycle after the load record for the same tag, with no conflicting store in between, answers in the next cycle with `chk_resp_valid`=1, `chk_ok`=1 and `chk_redo`=0.
- R3: A record covers the bytes from offset `ld_addr[2:0]` to that offset plus 2^`ld_size`−1 (`ld_size` 0=1 byte, 1=2, 2=4, 3=8). Bytes past offset 7 are dropped. A store kills the record when `st_dword` equals `ld_addr[ADDR_W-1:3]` and `st_be` bit k is set for some covered byte k. The check on that record then answers `chk_redo`=1 and `chk_ok`=0.
- R4: A store leaves a record untouched when it names a different dword, when it sets only bytes the record does not cover, or when `st_valid` is low.
- R5: A check on a tag with no live record answers `chk_redo`=1.
- R6: A check that passes releases its record, so a second check on that tag answers `chk_redo`=1.
- R7: A new load record on a tag that already has a live record replaces it. Only the newer address is then compared with stores.
- R8: When all NUM_SLOTS slots are live and a load arrives for a new tag, the slot named by a round-robin pointer is overwritten. The pointer starts at slot 0 after reset and advances by one, wrapping, on each such overwrite. Empty slots are filled lowest index first.
- R9: A store and a load record in the same cycle to overlapping bytes leave the new record live, because the load counts as later.
- R10: A store in the same cycle as a check already counts against that check.
- R11: A response arrives exactly one cycle after each check and in no other cycle. In a response cycle exactly one of `chk_ok` and `chk_redo` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | Record a speculative load this cycle |
| ld_tag | input | TAG_W | Destination register tag of the load |
| ld_addr | input | ADDR_W | Byte address of the load |
| ld_size | input | 2 | Log2 of the access size in bytes |
| st_valid | input | 1 | Store snoop valid |
| st_dword | input | ADDR_W-3 | Dword address of the store |
| st_be | input | 8 | Byte enables of the store within its dword |
| chk_valid | input | 1 | Check request |
| chk_tag | input | TAG_W | Register tag to check |
| chk_resp_valid | output | 1 | Check response valid |
| chk_ok | output | 1 | Speculation survived |
| chk_redo | output | 1 | Load must be reissued |

## Verification
The bench builds the table with NUM_SLOTS=4, TAG_W=3 and ADDR_W=12. With only four slots, the full-table case is reached after four loads, so round-robin eviction and pointer wrap can be driven directly. The bench sweeps every access size against every start offset and every single store byte lane, which is 256 cases. The expected overlap is computed from the offset arithmetic, so clipping at the dword edge is covered in full. The corner cases are directed: same-cycle store with load, same-cycle store with check, tag overwrite, and release after a pass.

// File: rtl/slat_pkg.sv
package slat_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    // Byte lanes covered inside one dword, clipped at lane 7.
    function automatic logic [7:0] lane_mask(input logic [2:0] off, input logic [1:0] sz);
        logic [4:0]  n;
        logic [15:0] m;
        n = 5'd1 << sz;
        m = ((16'd1 << n) - 16'd1) << off;
        return m[7:0];
    endfunction

endpackage

// File: rtl/slat_entry_cmp.sv
module slat_entry_cmp #(
    parameter int TAG_W = 6,
    parameter int DW_W  = 29
) (
    input  logic             vld,
    input  logic [TAG_W-1:0] tag,
    input  logic [DW_W-1:0]  dw,
    input  logic [7:0]       mask,
    input  logic [TAG_W-1:0] ld_tag,
    input  logic [TAG_W-1:0] chk_tag,
    input  logic             st_valid,
    input  logic [DW_W-1:0]  st_dw,
    input  logic [7:0]       st_be,
    output logic             ld_hit,
    output logic             chk_hit,
    output logic             st_kill
);
    always_comb begin
        ld_hit  = vld && (tag == ld_tag);
        chk_hit = vld && (tag == chk_tag);
        st_kill = vld && st_valid && (dw == st_dw) && (|(mask & st_be));
    end
endmodule

// File: rtl/slat_pick.sv
module slat_pick #(
    parameter int N = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table #(
    parameter int NUM_SLOTS = 32,
    parameter int TAG_W     = 6,
    parameter int ADDR_W    = 32,
    localparam int DW_W     = ADDR_W - 3,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic              st_valid,
    input  logic [DW_W-1:0]   st_dword,
    input  logic [7:0]        st_be,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              chk_resp_valid,
    output logic              chk_ok,
    output logic              chk_redo
);
    import slat_pkg::*;

    typedef struct packed {
        logic [NUM_SLOTS-1:0]            vld;
        logic [NUM_SLOTS-1:0][TAG_W-1:0] tag;
        logic [NUM_SLOTS-1:0][DW_W-1:0]  dw;
        logic [NUM_SLOTS-1:0][7:0]       mask;
        logic [IDX_W-1:0]                rr;
        logic                            rsp;
        logic                            ok;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_SLOTS-1:0] ld_hit, chk_hit, st_kill;
    logic                 ld_hit_any, free_any;
    logic [IDX_W-1:0]     ld_hit_idx, free_idx;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        slat_entry_cmp #(.TAG_W(TAG_W), .DW_W(DW_W)) u_cmp (
            .vld      (state_q.vld[g]),
            .tag      (state_q.tag[g]),
            .dw       (state_q.dw[g]),
            .mask     (state_q.mask[g]),
            .ld_tag   (ld_tag),
            .chk_tag  (chk_tag),
            .st_valid (st_valid),
            .st_dw    (st_dword),
            .st_be    (st_be),
            .ld_hit   (ld_hit[g]),
            .chk_hit  (chk_hit[g]),
            .st_kill  (st_kill[g])
        );
    end

    slat_pick #(.N(NUM_SLOTS)) u_hit_pick (
        .vec (ld_hit),
        .any (ld_hit_any),
        .idx (ld_hit_idx)
    );

    slat_pick #(.N(NUM_SLOTS)) u_free_pick (
        .vec (~state_q.vld),
        .any (free_any),
        .idx (free_idx)
    );

    always_comb begin
        logic [IDX_W-1:0] slot;
        state_d     = state_q;
        state_d.rsp = chk_valid;
        state_d.ok  = chk_valid && (|(chk_hit & ~st_kill));

        // Stores kill first, a passing check releases its slot.
        state_d.vld = state_q.vld & ~st_kill & ~(chk_valid ? chk_hit : '0);

        slot = state_q.rr;
        if (ld_hit_any) begin
            slot = ld_hit_idx;
        end else if (free_any) begin
            slot = free_idx;
        end

        if (ld_valid) begin
            if (!ld_hit_any && !free_any) begin
                state_d.rr = (state_q.rr == IDX_W'(NUM_SLOTS - 1)) ? '0 : state_q.rr + 1'b1;
            end
            state_d.vld[slot]  = 1'b1;
            state_d.tag[slot]  = ld_tag;
            state_d.dw[slot]   = ld_addr[ADDR_W-1:3];
            state_d.mask[slot] = lane_mask(ld_addr[2:0], ld_size);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign chk_resp_valid = state_q.rsp;
    assign chk_ok         = state_q.rsp && state_q.ok;
    assign chk_redo       = state_q.rsp && !state_q.ok;

    // R11
    resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> chk_resp_valid);

    // R11
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> !chk_resp_valid);

    // R5
    miss_gives_redo_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && !(|chk_hit)) |=> chk_redo);

    // R10
    same_cycle_kill_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && (|(chk_hit & st_kill))) |=> chk_redo);

    // R9
    load_occupies_chk: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> ($countones(state_q.vld) != 0));

    // R8
    full_stays_full_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !st_valid && !chk_valid && ($countones(state_q.vld) == NUM_SLOTS))
        |=> ($countones(state_q.vld) == NUM_SLOTS));

endmodule

// File: tb/spec_load_table_test.sv
module spec_load_table_test;
    localparam int N      = 4;
    localparam int TAG_W  = 3;
    localparam int ADDR_W = 12;
    localparam int DW_W   = ADDR_W - 3;

    logic              clk = 1'b0;
    logic              rst;
    logic              ld_valid;
    logic [TAG_W-1:0]  ld_tag;
    logic [ADDR_W-1:0] ld_addr;
    logic [1:0]        ld_size;
    logic              st_valid;
    logic [DW_W-1:0]   st_dword;
    logic [7:0]        st_be;
    logic              chk_valid;
    logic [TAG_W-1:0]  chk_tag;
    logic              chk_resp_valid, chk_ok, chk_redo;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    spec_load_table #(.NUM_SLOTS(N), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst),
        .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_size(ld_size),
        .st_valid(st_valid), .st_dword(st_dword), .st_be(st_be),
        .chk_valid(chk_valid), .chk_tag(chk_tag),
        .chk_resp_valid(chk_resp_valid), .chk_ok(chk_ok), .chk_redo(chk_redo)
    );

    task automatic clear_in();
        ld_valid = 0; ld_tag = '0; ld_addr = '0; ld_size = '0;
        st_valid = 0; st_dword = '0; st_be = '0;
        chk_valid = 0; chk_tag = '0;
    endtask

    // Called at a negedge; inputs held for one rising edge.
    task automatic step(input bit lv, input int lt, input int la, input int ls,
                        input bit sv, input int sd, input int sb,
                        input bit cv, input int ct);
        ld_valid = lv; ld_tag = TAG_W'(lt); ld_addr = ADDR_W'(la); ld_size = 2'(ls);
        st_valid = sv; st_dword = DW_W'(sd); st_be = 8'(sb);
        chk_valid = cv; chk_tag = TAG_W'(ct);
        @(negedge clk);
        clear_in();
    endtask

    task automatic expect_resp(input bit exp_ok, input string req);
        checks++;
        if (!(chk_resp_valid === 1'b1 && chk_ok === exp_ok && chk_redo === !exp_ok)) begin
            errors++;
            $display("FAIL %s: resp=%b ok=%b redo=%b expected resp=1 ok=%b redo=%b",
                     req, chk_resp_valid, chk_ok, chk_redo, exp_ok, !exp_ok);
        end
    endtask

    task automatic do_reset();
        rst = 1;
        clear_in();
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic load(input int t, input int a, input int s);
        step(1, t, a, s, 0, 0, 0, 0, 0);
    endtask

    task automatic store(input int d, input int b);
        step(0, 0, 0, 0, 1, d, b, 0, 0);
    endtask

    task automatic check(input int t, input bit exp_ok, input string req);
        step(0, 0, 0, 0, 0, 0, 0, 1, t);
        expect_resp(exp_ok, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1;
        clear_in();
        @(negedge clk);
        do_reset();
        // R1 reset state and idle response
        checks++;
        if (chk_resp_valid !== 0 || chk_ok !== 0 || chk_redo !== 0) begin
            errors++;
            $display("FAIL R1: resp=%b ok=%b redo=%b expected 0 0 0", chk_resp_valid, chk_ok, chk_redo);
        end
        for (int t = 0; t < 8; t++) check(t, 0, "R1");

        // R2 basic pass, R6 release
        load(2, 12'h040, 3);
        check(2, 1, "R2");
        check(2, 0, "R6");
        // R5 never-recorded tag
        check(6, 0, "R5");

        // R4 store to another dword, and st_valid low with matching address
        load(1, 12'h048, 2);
        store(12'h050 >> 3, 8'hFF);
        step(0, 0, 0, 0, 0, 12'h048 >> 3, 8'hFF, 0, 0);
        check(1, 1, "R4");

        // R3 and R4 exhaustive sweep: size x offset x single store lane
        for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < 8; off++) begin
                for (int b = 0; b < 8; b++) begin
                    int hi;
                    bit hit;
                    hi  = off + (1 << sz);
                    if (hi > 8) hi = 8;
                    hit = (b >= off) && (b < hi);
                    load(3, (5 << 3) + off, sz);
                    store(5, 1 << b);
                    check(3, !hit, hit ? "R3" : "R4");
                end
            end
        end

        // R7 overwrite on the same tag
        load(4, 12'h100, 3);
        load(4, 12'h200, 3);
        store(12'h100 >> 3, 8'hFF);
        check(4, 1, "R7");
        load(4, 12'h100, 3);
        load(4, 12'h200, 3);
        store(12'h200 >> 3, 8'h01);
        check(4, 0, "R7");

        // R9 same-cycle store and load to the same bytes
        step(1, 5, 12'h300, 3, 1, 12'h300 >> 3, 8'hFF, 0, 0);
        check(5, 1, "R9");

        // R10 store in the same cycle as the check
        load(6, 12'h308, 0);
        step(0, 0, 0, 0, 1, 12'h308 >> 3, 8'h01, 1, 6);
        expect_resp(0, "R10");

        // R11 no response in a quiet cycle
        @(negedge clk);
        checks++;
        if (chk_resp_valid !== 0 || chk_ok !== 0 || chk_redo !== 0) begin
            errors++;
            $display("FAIL R11: resp=%b ok=%b redo=%b expected 0 0 0", chk_resp_valid, chk_ok, chk_redo);
        end

        // R8 round-robin eviction when full
        do_reset();
        for (int t = 0; t < 4; t++) load(t, 12'h400 + t * 8, 3);
        load(4, 12'h480, 3);   // evicts slot 0 (tag 0)
        load(5, 12'h488, 3);   // evicts slot 1 (tag 1)
        check(0, 0, "R8");
        check(1, 0, "R8");
        check(2, 1, "R8");
        check(3, 1, "R8");
        check(4, 1, "R8");
        check(5, 1, "R8");
        // pointer continues at slot 2 after refill
        for (int t = 0; t < 4; t++) load(t, 12'h500 + t * 8, 3);
        load(6, 12'h580, 3);   // slot 2 again holds lowest free refill order: tags 0..3 in slots 0..3, evict slot 2 (tag 2)
        check(2, 0, "R8");
        check(0, 1, "R8");
        check(6, 1, "R8");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule